// File: doc/BRIEF.md
# MAC interrupt status aggregator

This block keeps the interrupt status and interrupt enable registers of an Ethernet MAC. It also holds the MAC command register. Single-cycle event pulses from the transmit and receive datapaths arrive on a plain bit vector and are latched into the status register. Software reads these registers through a small register port and clears status bits by writing ones to them.

Two bits inside the status register act as per-direction summaries. The transmit summary is set when any transmit cause is both pending and enabled. The receive summary follows the same rule for the receive causes. Each summary drives its own interrupt line, and that line is gated by the enable bit at the summary's own position.

Writing the command register with its soft-reset bit set returns the block to its reset state. Two mode bits of the command register survive a soft reset. The whole soft reset takes one clock.

All outputs are registered. An event or a write takes effect at the clock edge where it is sampled, and no path runs from the register port or the event inputs to the interrupt lines without passing through a flop.

Top module: `mac_irq_agg`

## Requirements
- R1: Each event input bit that lies in a cause mask (transmit causes are bits 31..17, receive causes are bits 15..1) is ORed into the status bit at the same position, and no other status bit changes because of it. Event bits at positions 16 and 0 are ignored.
- R2: Status bit 16, the transmit summary, is 1 exactly when some bit in 31..17 is set in both status and enable. Status bit 0, the receive summary, is 1 exactly when some bit in 15..1 is set in both status and enable.
- R3: irq_tx is high exactly when status bit 16 and enable bit 16 are both 1. irq_rx is high exactly when status bit 0 and enable bit 0 are both 1.
- R4: A write to address 0 clears exactly the cause bits written as 1 and leaves every other cause bit unchanged. Both summaries and both interrupt lines are re-evaluated in the same clock.
- R5: A write to address 1 replaces all 32 enable bits. Both summaries and both interrupt lines are re-evaluated against the new enable value in the same clock.
- R6: Event and write effects on status, summaries and interrupt lines appear one clock after they are sampled, never earlier. A read request returns the register's value from before that edge on bus_rdata one clock later, and bus_rdata then holds that value. Address 0 selects status, address 1 selects enable, address 2 selects command, and address 3 reads as zero.
- R7: When an event and a write-1-to-clear hit the same status bit in the same cycle, the bit stays set.
- R8: A write to address 2 with bit 24 set is a soft reset. Status and enable clear, and both interrupt lines go low on the next clock. The command register keeps only bits 21 and 20 of its value from before the write. A soft reset overrides events that arrive in the same cycle.
- R9: After reset, status, enable and command all read zero and both interrupt lines are low. A write to address 2 with bit 24 clear stores the written value, and bit 24 always reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write request |
| bus_re | input | 1 | Register read request |
| bus_addr | input | 2 | Register select: 0 status, 1 enable, 2 command |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid one clock after bus_re |
| ev_in | input | 32 | Event pulses from the datapaths, one bit per status position |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rx | output | 1 | Receive interrupt line |

## Verification
Software clears and the datapaths set the same status bits, so a clearing write and an event pulse can land on one bit in the same cycle. A soft reset and an event burst can also coincide. The bench provokes both directly: it pulses an event on a bit while writing a one to that same bit, and it raises events in the cycle of a soft-reset write. A long stretch of random traffic then makes these overlaps occur often. A behavioural model that gives events priority over clears, and soft reset priority over everything, judges each outcome through readback and through the two interrupt lines on every clock.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;

    localparam int unsigned REG_AW  = 2;
    localparam int unsigned NUM_DIR = 2;

    typedef enum logic [REG_AW-1:0] {
        ADDR_STAT = 2'd0,
        ADDR_EN   = 2'd1,
        ADDR_CMD  = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic stat_w1c;
        logic en_wr;
        logic cmd_wr;
    } wr_strb_t;

endpackage

// File: rtl/mac_irq_decode.sv
module mac_irq_decode
    import mac_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] stat_q,
    input  logic [DATA_W-1:0] en_q,
    input  logic [DATA_W-1:0] cmd_q,
    output wr_strb_t          strb,
    output logic [DATA_W-1:0] bus_rdata
);

    logic [DATA_W-1:0] rd_d;
    logic [DATA_W-1:0] rd_q;
    reg_addr_e         sel;

    assign sel = reg_addr_e'(bus_addr);

    always_comb begin
        strb          = '0;
        strb.stat_w1c = bus_we && (sel == ADDR_STAT);
        strb.en_wr    = bus_we && (sel == ADDR_EN);
        strb.cmd_wr   = bus_we && (sel == ADDR_CMD);
        rd_d          = rd_q;
        if (bus_re) begin
            case (sel)
                ADDR_STAT: rd_d = stat_q;
                ADDR_EN:   rd_d = en_q;
                ADDR_CMD:  rd_d = cmd_q;
                default:   rd_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rdata = rd_q;

    AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == 2'd3) |=> (bus_rdata == '0)); // R6

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata)); // R6

endmodule

// File: rtl/mac_irq_cmd.sv
module mac_irq_cmd #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned SRST_BIT  = 24,
    parameter int unsigned LBK_BIT   = 21,
    parameter int unsigned OPMOD_BIT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cmd_q,
    output logic              srst
);

    localparam logic [DATA_W-1:0] KEEP_MASK =
        (DATA_W'(1) << LBK_BIT) | (DATA_W'(1) << OPMOD_BIT);
    localparam logic [DATA_W-1:0] SRST_MASK = DATA_W'(1) << SRST_BIT;

    logic [DATA_W-1:0] cmd_d;

    assign srst = cmd_wr && wdata[SRST_BIT];

    always_comb begin
        cmd_d = cmd_q;
        if (srst) begin
            cmd_d = cmd_q & KEEP_MASK;
        end else if (cmd_wr) begin
            cmd_d = wdata & ~SRST_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else begin
            cmd_q <= cmd_d;
        end
    end

    AST_SRST_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (cmd_q == ($past(cmd_q) & KEEP_MASK))); // R8

    AST_CMD_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !srst) |=> (cmd_q == $past(wdata))); // R9

endmodule

// File: rtl/mac_irq_status.sv
module mac_irq_status
    import mac_irq_pkg::*;
#(
    parameter int unsigned       DATA_W        = 32,
    parameter logic [DATA_W-1:0] TX_CAUSE_MASK = 32'hFFFE_0000,
    parameter logic [DATA_W-1:0] RX_CAUSE_MASK = 32'h0000_FFFE,
    parameter int unsigned       TX_SUM_BIT    = 16,
    parameter int unsigned       RX_SUM_BIT    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ev_in,
    input  logic              stat_w1c,
    input  logic              en_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              srst,
    output logic [DATA_W-1:0] stat_q,
    output logic [DATA_W-1:0] en_q,
    output logic              irq_tx,
    output logic              irq_rx
);

    localparam int unsigned DIR_RX = 0;
    localparam int unsigned DIR_TX = 1;
    localparam logic [DATA_W-1:0] CAUSE_MASK = TX_CAUSE_MASK | RX_CAUSE_MASK;
    localparam logic [NUM_DIR-1:0][DATA_W-1:0] DIR_MASK = {TX_CAUSE_MASK, RX_CAUSE_MASK};
    localparam int unsigned DIR_SUM_BIT [NUM_DIR] = '{RX_SUM_BIT, TX_SUM_BIT};

    typedef struct packed {
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] en;
        logic              irq_tx;
        logic              irq_rx;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic [DATA_W-1:0]  ev_m;
    logic [DATA_W-1:0]  clr_m;
    logic [DATA_W-1:0]  cause_n;
    logic [DATA_W-1:0]  en_n;
    logic [NUM_DIR-1:0] dir_hit;
    logic [NUM_DIR-1:0] dir_irq;
    logic [NUM_DIR-1:0][DATA_W-1:0] sum_vec;

    assign ev_m    = ev_in & CAUSE_MASK;
    assign clr_m   = stat_w1c ? wdata : '0;
    assign cause_n = ((st_q.stat & CAUSE_MASK) & ~clr_m) | ev_m;
    assign en_n    = en_wr ? wdata : st_q.en;

    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
        assign dir_hit[g] = |(cause_n & en_n & DIR_MASK[g]);
        assign sum_vec[g] = dir_hit[g] ? (DATA_W'(1) << DIR_SUM_BIT[g]) : '0;
        assign dir_irq[g] = dir_hit[g] && en_n[DIR_SUM_BIT[g]];
    end

    always_comb begin
        st_d        = st_q;
        st_d.stat   = cause_n | sum_vec[DIR_TX] | sum_vec[DIR_RX];
        st_d.en     = en_n;
        st_d.irq_tx = dir_irq[DIR_TX];
        st_d.irq_rx = dir_irq[DIR_RX];
        if (srst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_q = st_q.stat;
    assign en_q   = st_q.en;
    assign irq_tx = st_q.irq_tx;
    assign irq_rx = st_q.irq_rx;

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_m && !srst) |=> ((stat_q & $past(ev_m)) == $past(ev_m))); // R1

    AST_TX_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[TX_SUM_BIT] == |(stat_q & en_q & TX_CAUSE_MASK)); // R2

    AST_RX_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[RX_SUM_BIT] == |(stat_q & en_q & RX_CAUSE_MASK)); // R2

    AST_TX_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx == (stat_q[TX_SUM_BIT] && en_q[TX_SUM_BIT])); // R3

    AST_RX_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx == (stat_q[RX_SUM_BIT] && en_q[RX_SUM_BIT])); // R3

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_w1c && !srst) |=> ((stat_q & $past(wdata & ~ev_in) & CAUSE_MASK) == '0)); // R4

    AST_EN_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !srst) |=> (en_q == $past(wdata))); // R5

    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_w1c && !srst && |(wdata & ev_m))
        |=> ((stat_q & $past(wdata & ev_m)) == $past(wdata & ev_m))); // R7

    AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!irq_tx && !irq_rx && stat_q == '0 && en_q == '0)); // R8

endmodule

// File: rtl/mac_irq_agg.sv
module mac_irq_agg
    import mac_irq_pkg::*;
#(
    parameter int unsigned       DATA_W        = 32,
    parameter logic [DATA_W-1:0] TX_CAUSE_MASK = 32'hFFFE_0000,
    parameter logic [DATA_W-1:0] RX_CAUSE_MASK = 32'h0000_FFFE,
    parameter int unsigned       TX_SUM_BIT    = 16,
    parameter int unsigned       RX_SUM_BIT    = 0,
    parameter int unsigned       SRST_BIT      = 24,
    parameter int unsigned       LBK_BIT       = 21,
    parameter int unsigned       OPMOD_BIT     = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] ev_in,
    output logic              irq_tx,
    output logic              irq_rx
);

    wr_strb_t          strb;
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] en_q;
    logic [DATA_W-1:0] cmd_q;
    logic              srst;

    mac_irq_decode #(
        .DATA_W (DATA_W)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .stat_q    (stat_q),
        .en_q      (en_q),
        .cmd_q     (cmd_q),
        .strb      (strb),
        .bus_rdata (bus_rdata)
    );

    mac_irq_cmd #(
        .DATA_W    (DATA_W),
        .SRST_BIT  (SRST_BIT),
        .LBK_BIT   (LBK_BIT),
        .OPMOD_BIT (OPMOD_BIT)
    ) u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_wr (strb.cmd_wr),
        .wdata  (bus_wdata),
        .cmd_q  (cmd_q),
        .srst   (srst)
    );

    mac_irq_status #(
        .DATA_W        (DATA_W),
        .TX_CAUSE_MASK (TX_CAUSE_MASK),
        .RX_CAUSE_MASK (RX_CAUSE_MASK),
        .TX_SUM_BIT    (TX_SUM_BIT),
        .RX_SUM_BIT    (RX_SUM_BIT)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_in    (ev_in),
        .stat_w1c (strb.stat_w1c),
        .en_wr    (strb.en_wr),
        .wdata    (bus_wdata),
        .srst     (srst),
        .stat_q   (stat_q),
        .en_q     (en_q),
        .irq_tx   (irq_tx),
        .irq_rx   (irq_rx)
    );

endmodule

// File: tb/mac_irq_agg_test.sv
module mac_irq_agg_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] ev_in = '0;
    logic        irq_tx;
    logic        irq_rx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_stat, m_en, m_cmd, m_rd;
    logic        m_itx, m_irx;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_irq_agg uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ev_in     (ev_in),
        .irq_tx    (irq_tx),
        .irq_rx    (irq_rx)
    );

    // Behavioural reference: events beat clears, soft reset beats everything.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_stat = '0; m_en = '0; m_cmd = '0; m_rd = '0; m_itx = 0; m_irx = 0;
        end else begin
            logic tx_any, rx_any;
            if (bus_re) begin
                case (bus_addr)
                    2'd0: m_rd = m_stat;
                    2'd1: m_rd = m_en;
                    2'd2: m_rd = m_cmd;
                    default: m_rd = '0;
                endcase
            end
            if (bus_we && bus_addr == 2'd2 && bus_wdata[24]) begin
                m_cmd = m_cmd & 32'h0030_0000;
                m_stat = '0; m_en = '0; m_itx = 0; m_irx = 0;
            end else begin
                if (bus_we && bus_addr == 2'd2) m_cmd = bus_wdata & 32'hFEFF_FFFF;
                if (bus_we && bus_addr == 2'd1) m_en = bus_wdata;
                for (int i = 0; i < 32; i++) begin
                    if (i != 0 && i != 16)
                        m_stat[i] = (m_stat[i] && !(bus_we && bus_addr == 2'd0 && bus_wdata[i]))
                                    || ev_in[i];
                end
                tx_any = 0;
                rx_any = 0;
                for (int i = 17; i < 32; i++) if (m_stat[i] && m_en[i]) tx_any = 1;
                for (int i = 1; i < 16; i++) if (m_stat[i] && m_en[i]) rx_any = 1;
                m_stat[16] = tx_any;
                m_stat[0]  = rx_any;
                m_itx = tx_any && m_en[16];
                m_irx = rx_any && m_en[0];
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Comparison against the model on every clock.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 irq_tx vs model", {31'd0, irq_tx}, {31'd0, m_itx});
            check("R3 irq_rx vs model", {31'd0, irq_rx}, {31'd0, m_irx});
            check("R6 bus_rdata vs model", bus_rdata, m_rd);
        end
    end

    task automatic cyc(input logic we, input logic re, input logic [1:0] a,
                       input logic [31:0] wd, input logic [31:0] ev);
        @(negedge clk);
        bus_we = we; bus_re = re; bus_addr = a; bus_wdata = wd; ev_in = ev;
    endtask

    task automatic idle();
        cyc(0, 0, 2'd0, '0, '0);
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
        cyc(0, 1, a, '0, '0);
        idle();
        check(tag, bus_rdata, exp);
    endtask

    task automatic irq_chk(input logic etx, input logic erx, input string tag);
        check({tag, " irq_tx"}, {31'd0, irq_tx}, {31'd0, etx});
        check({tag, " irq_rx"}, {31'd0, irq_rx}, {31'd0, erx});
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R9 reset values
        rd_chk(2'd0, 32'h0, "R9 status after reset");
        rd_chk(2'd1, 32'h0, "R9 enable after reset");
        rd_chk(2'd2, 32'h0, "R9 command after reset");
        irq_chk(0, 0, "R9 reset");
        // R1 events latch, summary positions ignored
        cyc(0, 0, 2'd0, '0, 32'h0000_0028);
        cyc(0, 0, 2'd0, '0, 32'h0001_0001);
        idle();
        rd_chk(2'd0, 32'h0000_0028, "R1 events ORed, bits 16/0 ignored");
        irq_chk(0, 0, "R1 nothing enabled");
        // R5 enable write re-evaluates
        cyc(1, 0, 2'd1, 32'h0000_0009, '0);
        idle();
        rd_chk(2'd0, 32'h0000_0029, "R2 rx summary set");
        irq_chk(0, 1, "R3 rx line");
        rd_chk(2'd1, 32'h0000_0009, "R5 enable replaced");
        // R3 summary without its own enable bit
        cyc(1, 0, 2'd1, 32'h0000_0008, '0);
        idle();
        rd_chk(2'd0, 32'h0000_0029, "R3 summary kept");
        irq_chk(0, 0, "R3 line gated by bit 0 enable");
        cyc(1, 0, 2'd1, 32'h0000_0009, '0);
        // R2 transmit side
        cyc(0, 0, 2'd0, '0, 32'h0010_0000);
        idle();
        rd_chk(2'd0, 32'h0010_0029, "R2 tx cause not enabled");
        irq_chk(0, 1, "R2 no tx yet");
        cyc(1, 0, 2'd1, 32'h0011_0009, '0);
        idle();
        rd_chk(2'd0, 32'h0011_0029, "R2 tx summary set");
        irq_chk(1, 1, "R3 both lines");
        // R4 write-1-to-clear
        cyc(1, 0, 2'd0, 32'h0000_0008, '0);
        idle();
        rd_chk(2'd0, 32'h0011_0020, "R4 clear bit 3 only");
        irq_chk(1, 0, "R4 rx re-evaluated");
        // R7 event beats clear
        cyc(1, 0, 2'd0, 32'h0010_0000, 32'h0010_0000);
        idle();
        rd_chk(2'd0, 32'h0011_0020, "R7 event wins");
        irq_chk(1, 0, "R7 tx still up");
        cyc(1, 0, 2'd0, 32'h0010_0000, '0);
        idle();
        rd_chk(2'd0, 32'h0000_0020, "R4 tx cause cleared");
        irq_chk(0, 0, "R4 tx re-evaluated");
        // R6 one-clock latency
        cyc(0, 0, 2'd0, '0, 32'h0000_0008);
        check("R6 no early output", {31'd0, irq_rx}, 32'd0);
        idle();
        check("R6 output after one clock", {31'd0, irq_rx}, 32'd1);
        rd_chk(2'd3, 32'h0, "R6 hole reads zero");
        // R9 command store
        cyc(1, 0, 2'd2, 32'h00F0_FFFF, '0);
        idle();
        rd_chk(2'd2, 32'h00F0_FFFF, "R9 command stored");
        irq_chk(0, 1, "R8 line up before soft reset");
        // R8 soft reset with concurrent event
        cyc(1, 0, 2'd2, 32'h0100_0000, 32'h0000_0004);
        idle();
        irq_chk(0, 0, "R8 soft reset lines");
        rd_chk(2'd2, 32'h0030_0000, "R8 mode bits kept");
        rd_chk(2'd0, 32'h0, "R8 status cleared, event dropped");
        rd_chk(2'd1, 32'h0, "R8 enable cleared");
        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] wd, ev;
            logic [1:0]  a;
            logic        we;
            wd = $urandom;
            a  = 2'($urandom_range(0, 3));
            we = ($urandom_range(0, 3) == 0);
            ev = $urandom & $urandom & $urandom;
            if (a == 2'd2 && $urandom_range(0, 15) != 0) wd[24] = 1'b0;
            if (a == 2'd0 && $urandom_range(0, 1) == 0) wd = wd | ev;
            cyc(we, $urandom_range(0, 1) == 1, a, wd, ev);
        end
        idle();
        idle();
        done = 1'b1;
        finish_run();
    end

endmodule